// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator with Buffered Update

This block produces one pulse-width-modulated waveform from a counter that advances on a selectable counting tick. The tick comes either from a power-of-two divider chain running on the master clock or from one of two auxiliary divided clocks that arrive from outside the block. The counter runs either as a sawtooth, where each period spans the period value in ticks, or as a triangle, where each period spans twice the period value. A polarity bit picks the level the output shows at the start of each period.

Software sets mode, duty and period directly while the channel is stopped. Once the channel runs, those direct writes are dropped. The only way to change the waveform while it runs is a single update register. A mode bit chooses whether its value replaces the duty or the period. The new value is held in a buffer and lands only when the counter returns to zero, so no period is ever cut short or stretched halfway. The live counter value is always visible on a read port.

Top module: `pwm_channel`

## Requirements
- R1: Prescaler field mode[3:0] codes 0 to 10 advance the counter once every 2^code master clock cycles (code 3 gives one step per 8 cycles, code 10 one step per 1024).
- R2: Prescaler code 11 advances the counter once per rising edge of auxClkA, and code 12 once per rising edge of auxClkB. The auxiliary input that is not selected has no effect on the counter.
- R3: With the alignment bit mode[8] at 0, the counter runs 0, 1, ... period-1 and then returns to 0, so a period lasts `period` steps.
- R4: With mode[8] at 1, the counter climbs from 0 to `period` and then descends to 1 before it returns to 0, so a period lasts 2*period steps.
- R5: Polarity bit mode[9] sets the start level: 0 starts low and 1 starts high. The output shows the start level while the counter is below the duty value and the opposite level otherwise.
- R6: A duty of 0 holds the output at the opposite of the start level. A duty equal to the period holds it at the start level for the whole period.
- R7: A write to the update register (wrSel 3) leaves the waveform unchanged until the counter next returns to 0. At that moment the value replaces the duty when mode[10] is 0, or the period when mode[10] is 1.
- R8: While chanEn is high, direct writes to mode (wrSel 0), duty (wrSel 1) and period (wrSel 2) are dropped.
- R9: Reset clears the counter, all settings and the pending update, so the output reads 1 (duty 0, polarity 0). While chanEn is low, the counter is held at 0, counting up.
- R10: cntOut shows the live counter value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | 1 | Channel run enable |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 2 | Write target: 0 mode, 1 duty, 2 period, 3 update |
| wrData | input | CNT_W | Write data |
| auxClkA | input | 1 | Auxiliary counting clock A, sampled on clk |
| auxClkB | input | 1 | Auxiliary counting clock B, sampled on clk |
| cntOut | output | CNT_W | Live counter value |
| pwmOut | output | 1 | Waveform output |

## Verification
A wrong counter direction or a wrong wrap point shows on cntOut in the step where it occurs. The wrong value then reaches pwmOut within the same period, because the number of start-level cycles in that period changes. An update buffer that is applied too early changes the level seen mid-period, before the counter reaches zero. One that is routed to the wrong target shows a full period later as a wrong period length or a wrong duty count. A prescaler that decodes the wrong tick shows as a wrong spacing between consecutive counter changes from the second step onward.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_UPDATE = 2'd3
  } wrSel_e;

  // mode word layout
  localparam int MODE_ALIGN_BIT = 8;
  localparam int MODE_POL_BIT   = 9;
  localparam int MODE_TGT_BIT   = 10;

  // prescaler codes
  localparam int MAX_DIV_CODE = 10;
  localparam int CLK_A_CODE   = 11;
  localparam int CLK_B_CODE   = 12;

  // strobes from control to datapath
  typedef struct packed {
    logic step;   // advance the counter this cycle
    logic clear;  // hold counter at zero, direction up
  } strobe_t;

endpackage

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             auxClkA,
  input  logic             auxClkB,
  input  logic             wrapEvt,
  output strobe_t          strb,
  output logic             align,
  output logic             pol,
  output logic [CNT_W-1:0] dty,
  output logic [CNT_W-1:0] prd
);

  localparam int DIV_W = MAX_DIV_CODE;

  logic [3:0]       preSel;
  logic             tgtPrd;
  logic [CNT_W-1:0] updBuf;
  logic             updPend;
  logic [DIV_W-1:0] divCnt;
  logic             auxASync, auxAPrev, auxBSync, auxBPrev;
  logic [MAX_DIV_CODE:0] divTick;
  logic             tick;

  // divider chain taps: tap k fires once every 2^k cycles
  assign divTick[0] = 1'b1;
  for (genvar k = 1; k <= MAX_DIV_CODE; k++) begin : g_tap
    assign divTick[k] = &divCnt[k-1:0];
  end

  always_comb begin
    tick = 1'b0;
    for (int k = 0; k <= MAX_DIV_CODE; k++) begin
      if (preSel == 4'(k)) tick = divTick[k];
    end
    if (preSel == 4'(CLK_A_CODE)) tick = auxASync & ~auxAPrev;
    if (preSel == 4'(CLK_B_CODE)) tick = auxBSync & ~auxBPrev;
  end

  assign strb.step  = chanEn & tick;
  assign strb.clear = ~chanEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      auxASync <= 1'b0;
      auxAPrev <= 1'b0;
      auxBSync <= 1'b0;
      auxBPrev <= 1'b0;
    end else begin
      divCnt   <= divCnt + 1'b1;
      auxASync <= auxClkA;
      auxAPrev <= auxASync;
      auxBSync <= auxClkB;
      auxBPrev <= auxBSync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preSel  <= '0;
      align   <= 1'b0;
      pol     <= 1'b0;
      tgtPrd  <= 1'b0;
      dty     <= '0;
      prd     <= '0;
      updBuf  <= '0;
      updPend <= 1'b0;
    end else begin
      if (wrEn && !chanEn) begin
        case (wrSel)
          SEL_MODE: begin
            preSel <= wrData[3:0];
            align  <= wrData[MODE_ALIGN_BIT];
            pol    <= wrData[MODE_POL_BIT];
            tgtPrd <= wrData[MODE_TGT_BIT];
          end
          SEL_DUTY:   dty <= wrData;
          SEL_PERIOD: prd <= wrData;
          default: ;
        endcase
      end
      if (wrapEvt && updPend) begin
        if (tgtPrd) prd <= updBuf;
        else        dty <= updBuf;
        updPend <= 1'b0;
      end
      if (wrEn && wrSel == SEL_UPDATE) begin
        updBuf  <= wrData;
        updPend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_chan_dp.sv
module pwm_chan_dp
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             align,
  input  logic             pol,
  input  logic [CNT_W-1:0] dty,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic             wrapEvt,
  output logic             pwmOut
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             countDown;
  logic [CNT_W:0]   nxtUp;
  logic             upHit;
  logic             lastDown;
  logic             startPhase;

  assign nxtUp    = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign upHit    = nxtUp >= {1'b0, prd};
  assign lastDown = countDown && (cnt <= ONE);

  assign wrapEvt = strb.step && (align ? lastDown : upHit);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      cnt       <= '0;
      countDown <= 1'b0;
    end else if (strb.step) begin
      if (align) begin
        if (!countDown) begin
          cnt <= nxtUp[CNT_W-1:0];
          if (upHit) countDown <= 1'b1;
        end else if (lastDown) begin
          cnt       <= '0;
          countDown <= 1'b0;
        end else begin
          cnt <= cnt - ONE;
        end
      end else begin
        cnt <= upHit ? '0 : nxtUp[CNT_W-1:0];
      end
    end
  end

  // start level below the duty, or for the whole period at full duty
  assign startPhase = (dty != '0) && ((dty >= prd) || (cnt < dty));
  assign pwmOut     = startPhase ? pol : ~pol;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             auxClkA,
  input  logic             auxClkB,
  output logic [CNT_W-1:0] cntOut,
  output logic             pwmOut
);

  strobe_t          strbW;
  logic             alignW, polW, wrapW;
  logic [CNT_W-1:0] dtyW, prdW;

  pwm_chan_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .chanEn  (chanEn),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .auxClkA (auxClkA),
    .auxClkB (auxClkB),
    .wrapEvt (wrapW),
    .strb    (strbW),
    .align   (alignW),
    .pol     (polW),
    .dty     (dtyW),
    .prd     (prdW)
  );

  pwm_chan_dp #(.CNT_W(CNT_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strbW),
    .align   (alignW),
    .pol     (polW),
    .dty     (dtyW),
    .prd     (prdW),
    .cnt     (cntOut),
    .wrapEvt (wrapW),
    .pwmOut  (pwmOut)
  );

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             chanEn,
  input logic [CNT_W-1:0] cntOut,
  input logic             pwmOut,
  input logic             align,
  input logic             pol,
  input logic [CNT_W-1:0] dty,
  input logic [CNT_W-1:0] prd,
  input logic             wrapEvt
);

  p_left_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && !align && prd != '0) |-> cntOut < prd);

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> cntOut == '0);

  p_center_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && align && prd != '0) |-> cntOut <= prd);

  p_full_duty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dty != '0 && dty >= prd) |-> pwmOut == pol);

  p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dty == '0) |-> pwmOut != pol);

  p_dty_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && !wrapEvt) |=> $stable(dty));

  p_prd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && !wrapEvt) |=> $stable(prd));

  p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> cntOut == '0);

endmodule

bind pwm_channel pwm_chan_chk #(.CNT_W(CNT_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .chanEn  (chanEn),
  .cntOut  (cntOut),
  .pwmOut  (pwmOut),
  .align   (alignW),
  .pol     (polW),
  .dty     (dtyW),
  .prd     (prdW),
  .wrapEvt (wrapW)
);

// File: tb/sim_pwm_channel.sv
`timescale 1ns/1ps
module sim_pwm_channel;

  localparam int CW = 16;
  localparam time CLK_P = 4ns;

  logic          clk = 1'b0;
  logic          rstN;
  logic          chanEn;
  logic          wrEn;
  logic [1:0]    wrSel;
  logic [CW-1:0] wrData;
  logic          auxClkA, auxClkB;
  logic [CW-1:0] cntOut;
  logic          pwmOut;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_channel #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .auxClkA(auxClkA), .auxClkB(auxClkB),
    .cntOut(cntOut), .pwmOut(pwmOut)
  );

  typedef struct packed {
    logic        align;
    logic        pol;
    logic [15:0] prd;
    logic [15:0] dty;
    logic [15:0] expStart;  // start-level cycles in one period
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'd8, 16'd3, 16'd3},
    '{1'b0, 1'b1, 16'd8, 16'd3, 16'd3},
    '{1'b0, 1'b0, 16'd8, 16'd0, 16'd0},
    '{1'b0, 1'b1, 16'd8, 16'd8, 16'd8},
    '{1'b1, 1'b0, 16'd5, 16'd2, 16'd3},
    '{1'b1, 1'b1, 16'd5, 16'd5, 16'd10},
    '{1'b1, 1'b1, 16'd5, 16'd0, 16'd0},
    '{1'b1, 1'b0, 16'd4, 16'd1, 16'd1},
    '{1'b0, 1'b1, 16'd1, 16'd1, 16'd1}
  };

  function automatic logic [CW-1:0] modeWord(int code, bit al, bit pl, bit tg);
    logic [CW-1:0] w;
    w = CW'(code);
    w[8]  = al;
    w[9]  = pl;
    w[10] = tg;
    return w;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [1:0] sel, logic [CW-1:0] data);
    wrSel  = sel;
    wrData = data;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic setup(logic [CW-1:0] mode, logic [CW-1:0] d, logic [CW-1:0] p);
    chanEn = 1'b0;
    writeReg(2'd0, mode);
    writeReg(2'd1, d);
    writeReg(2'd2, p);
    @(negedge clk);
  endtask

  task automatic stepSpacing(output int n);
    logic [CW-1:0] c0;
    c0 = cntOut;
    while (cntOut == c0) begin @(negedge clk); #1; end
    c0 = cntOut;
    n = 0;
    while (cntOut == c0) begin @(negedge clk); #1; n++; end
  endtask

  task automatic auxPulses(bit onA, int num);
    for (int i = 0; i < num; i++) begin
      if (onA) auxClkA = 1'b1; else auxClkB = 1'b1;
      repeat (3) @(negedge clk);
      auxClkA = 1'b0;
      auxClkB = 1'b0;
      repeat (3) @(negedge clk);
    end
    #1;
  endtask

  task automatic waitZero();
    while (cntOut != '0) begin @(negedge clk); #1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int n, startCnt, maxSeen, per;
    rstN = 1'b0; chanEn = 1'b0; wrEn = 1'b0; wrSel = '0; wrData = '0;
    auxClkA = 1'b0; auxClkB = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R9 reset counter", int'(cntOut), 0);
    check("R9 reset output", int'(pwmOut), 1);

    // table walk: alignment, polarity, duty corners
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      setup(modeWord(0, VECS[v].align, VECS[v].pol, 1'b0), VECS[v].dty, VECS[v].prd);
      chanEn = 1'b1;
      #1;
      per = VECS[v].align ? 2 * int'(VECS[v].prd) : int'(VECS[v].prd);
      startCnt = 0;
      for (int i = 0; i < per; i++) begin
        if (i > 0) begin @(negedge clk); #1; end
        if (pwmOut == VECS[v].pol) startCnt++;
      end
      @(negedge clk); #1;
      check(VECS[v].align ? "R4 period end at zero" : "R3 period end at zero",
            int'(cntOut), 0);
      check("R5/R6 start-level cycles", startCnt, int'(VECS[v].expStart));
    end

    // R1 prescaler spacing
    @(negedge clk);
    setup(modeWord(3, 1'b0, 1'b0, 1'b0), 16'd0, 16'd2000);
    chanEn = 1'b1; #1;
    stepSpacing(n);
    check("R1 code 3 spacing", n, 8);
    @(negedge clk);
    setup(modeWord(7, 1'b0, 1'b0, 1'b0), 16'd0, 16'd2000);
    chanEn = 1'b1; #1;
    stepSpacing(n);
    check("R1 code 7 spacing", n, 128);
    @(negedge clk);
    setup(modeWord(10, 1'b0, 1'b0, 1'b0), 16'd0, 16'd2000);
    chanEn = 1'b1; #1;
    stepSpacing(n);
    check("R1 code 10 spacing", n, 1024);
    check("R10 counter readable while running", int'(cntOut != 0), 1);

    // R2 auxiliary clocks
    @(negedge clk);
    setup(modeWord(11, 1'b0, 1'b0, 1'b0), 16'd0, 16'd100);
    chanEn = 1'b1;
    auxPulses(1'b0, 4);
    check("R2 clock B ignored under code 11", int'(cntOut), 0);
    auxPulses(1'b1, 5);
    check("R2 clock A edges under code 11", int'(cntOut), 5);
    @(negedge clk);
    setup(modeWord(12, 1'b0, 1'b0, 1'b0), 16'd0, 16'd100);
    chanEn = 1'b1;
    auxPulses(1'b1, 3);
    check("R2 clock A ignored under code 12", int'(cntOut), 0);
    auxPulses(1'b0, 6);
    check("R2 clock B edges under code 12", int'(cntOut), 6);

    // R7 update to duty
    @(negedge clk);
    setup(modeWord(0, 1'b0, 1'b0, 1'b0), 16'd2, 16'd10);
    chanEn = 1'b1;
    repeat (3) @(negedge clk);
    writeReg(2'd3, 16'd7);
    @(negedge clk); #1;
    check("R7 duty unchanged mid-period (count)", int'(cntOut), 5);
    check("R7 duty unchanged mid-period (level)", int'(pwmOut), 1);
    waitZero();
    startCnt = 0;
    for (int i = 0; i < 10; i++) begin
      if (i > 0) begin @(negedge clk); #1; end
      if (pwmOut == 1'b0) startCnt++;
    end
    check("R7 new duty after boundary", startCnt, 7);

    // R7 update to period
    @(negedge clk);
    setup(modeWord(0, 1'b0, 1'b0, 1'b1), 16'd2, 16'd10);
    chanEn = 1'b1;
    repeat (2) @(negedge clk);
    writeReg(2'd3, 16'd6);
    #1;
    maxSeen = 0;
    while (cntOut != '0) begin
      if (int'(cntOut) > maxSeen) maxSeen = int'(cntOut);
      @(negedge clk); #1;
    end
    check("R7 old period kept until boundary", maxSeen, 9);
    n = 0;
    do begin @(negedge clk); #1; n++; end while (cntOut != '0);
    check("R7 new period after boundary", n, 6);

    // R8 direct writes dropped while running
    writeReg(2'd1, 16'd5);
    writeReg(2'd0, modeWord(0, 1'b1, 1'b1, 1'b1));
    #1;
    waitZero();
    startCnt = 0;
    for (int i = 0; i < 6; i++) begin
      if (i > 0) begin @(negedge clk); #1; end
      if (pwmOut == 1'b0) startCnt++;
    end
    check("R8 duty and mode unchanged", startCnt, 2);
    @(negedge clk); #1;
    check("R8 period unchanged", int'(cntOut), 0);

    // R9 disable holds counter at zero
    repeat (3) @(negedge clk);
    #1;
    check("R9 counter running before disable", int'(cntOut), 3);
    @(negedge clk);
    chanEn = 1'b0;
    @(negedge clk); #1;
    check("R9 counter cleared when disabled", int'(cntOut), 0);
    repeat (4) @(negedge clk);
    #1;
    check("R9 counter held while disabled", int'(cntOut), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule